// File: doc/BRIEF.md
# Five-Function Integer ALU with Status Flags

This block is a purely combinational arithmetic-logic unit for two-operand integer work. A 3-bit operation code picks one of five functions: bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. The unit returns a data-width result together with three status bits: zero, signed overflow and carry-out.

Addition and subtraction share a single adder. To subtract, the B operand is inverted and the carry-in is forced high. Set-on-less-than also runs through that subtract path. It takes the sign of the difference and corrects it with the overflow flag, so the comparison stays right when the difference leaves the signed range. Signed overflow comes from comparing the operand signs with the result sign. Code that uses the block places it between the operand sources and a result register, and reads the flags in the same cycle.

Top module: `alu5_core`

## Requirements
- R1: Operation code 3'b000 returns the bitwise AND of A and B.
- R2: Operation code 3'b001 returns the bitwise OR of A and B.
- R3: Operation code 3'b010 returns (A + B) modulo 2^W. The carry flag is bit W of the unsigned sum.
- R4: Operation code 3'b110 returns (A + ~B + 1) modulo 2^W, which equals A - B. The carry flag is bit W of that sum, so it is 1 exactly when A >= B as unsigned numbers.
- R5: For code 3'b010, the overflow flag is 1 exactly when A and B have equal sign bits and the result's sign bit differs from them.
- R6: For code 3'b110, the overflow flag is 1 exactly when A and B have different sign bits and the result's sign bit differs from the sign bit of A.
- R7: Operation code 3'b111 returns 1 in bit 0 and 0 in every other bit when A < B as signed two's-complement numbers, and returns all zeros otherwise. The result is correct even when A - B overflows. For this code the overflow and carry flags report the internal subtraction A - B.
- R8: For every defined code (000, 001, 010, 110, 111), the zero flag is 1 exactly when all W result bits are 0.
- R9: For codes 000 and 001, the overflow and carry flags are 0.
- R10: Codes 011, 100 and 101 give a result of 0 with the zero, overflow and carry flags all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code |
| opnd_a | input | DATA_W (32) | First operand (A) |
| opnd_b | input | DATA_W (32) | Second operand (B) |
| res | output | DATA_W (32) | Result of the selected operation |
| zero_flag | output | 1 | Result is all zeros (defined codes only) |
| ovf_flag | output | 1 | Signed overflow of the add or subtract path |
| carry_flag | output | 1 | Carry out of the adder's top bit |

## Verification
Directed operand pairs sit at the signed extremes: the largest positive value plus one, the most negative value minus one, and the most negative value compared against the largest positive. These pairs separate the correct overflow rule, and the overflow-corrected less-than, from a naive sign test. Equal operands and all-zero operands show whether the zero flag and the carry flag of subtraction behave correctly. Pairs whose signs are equal and pairs whose signs are mixed show whether the add rule and the subtract rule are swapped. A long run of pseudo-random operands over all eight codes, including the three unused ones, checks that the decode gives no code the wrong behaviour.

// File: rtl/alu5_pkg.sv
package alu5_pkg;

  localparam logic [2:0] OPC_AND = 3'b000;
  localparam logic [2:0] OPC_OR  = 3'b001;
  localparam logic [2:0] OPC_ADD = 3'b010;
  localparam logic [2:0] OPC_SUB = 3'b110;
  localparam logic [2:0] OPC_SLT = 3'b111;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LOGIC = 2'd1,
    SRC_SUM   = 2'd2,
    SRC_LESS  = 2'd3
  } res_src_e;

  typedef struct packed {
    logic     valid;
    logic     negate_b;
    logic     pick_or;
    res_src_e src;
  } alu_ctrl_t;

endpackage

// File: rtl/alu5_decode.sv
module alu5_decode
  import alu5_pkg::*;
(
  input  logic [2:0] op_sel,
  output alu_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '{valid: 1'b0, negate_b: 1'b0, pick_or: 1'b0, src: SRC_NONE};
    case (op_sel)
      OPC_AND: begin
        ctrl.valid = 1'b1;
        ctrl.src   = SRC_LOGIC;
      end
      OPC_OR: begin
        ctrl.valid   = 1'b1;
        ctrl.pick_or = 1'b1;
        ctrl.src     = SRC_LOGIC;
      end
      OPC_ADD: begin
        ctrl.valid = 1'b1;
        ctrl.src   = SRC_SUM;
      end
      OPC_SUB: begin
        ctrl.valid    = 1'b1;
        ctrl.negate_b = 1'b1;
        ctrl.src      = SRC_SUM;
      end
      OPC_SLT: begin
        ctrl.valid    = 1'b1;
        ctrl.negate_b = 1'b1;
        ctrl.src      = SRC_LESS;
      end
      default: ctrl = '{valid: 1'b0, negate_b: 1'b0, pick_or: 1'b0, src: SRC_NONE};
    endcase
  end

  // R10: unused codes never mark the operation as valid
  always_comb begin
    p_unused_invalid_r10: assert (!((op_sel == 3'b011 || op_sel == 3'b100 ||
                                     op_sel == 3'b101) && ctrl.valid))
      else $error("unused code decoded as valid");
  end

endmodule

// File: rtl/alu5_addsub.sv
module alu5_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              negate_b,
  output logic [DATA_W-1:0] sum,
  output logic              carry_out,
  output logic              ovf,
  output logic              less
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  always_comb begin
    b_eff     = b_in ^ {DATA_W{negate_b}};
    wide      = {1'b0, a_in} + {1'b0, b_eff} + {{DATA_W{1'b0}}, negate_b};
    sum       = wide[MSB:0];
    carry_out = wide[DATA_W];
    ovf       = (a_in[MSB] == b_eff[MSB]) && (sum[MSB] != a_in[MSB]);
    less      = sum[MSB] ^ ovf;
  end

  always_comb begin
    // R4: carry of the subtract path means no unsigned borrow
    p_sub_carry_r4: assert (!negate_b || (carry_out == (a_in >= b_in)))
      else $error("subtract carry mismatch");
    // R5: add overflow from raw operand signs
    p_add_ovf_r5: assert (negate_b ||
        (ovf == ((a_in[MSB] == b_in[MSB]) && (sum[MSB] != b_in[MSB]))))
      else $error("add overflow mismatch");
    // R6: subtract overflow from raw operand signs
    p_sub_ovf_r6: assert (!negate_b ||
        (ovf == ((a_in[MSB] != b_in[MSB]) && (sum[MSB] != a_in[MSB]))))
      else $error("subtract overflow mismatch");
    // R7: less equals signed comparison while subtracting
    p_less_r7: assert (!negate_b || (less == ($signed(a_in) < $signed(b_in))))
      else $error("signed less mismatch");
  end

endmodule

// File: rtl/alu5_logic.sv
module alu5_logic #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              pick_or,
  output logic [DATA_W-1:0] y
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign y[i] = pick_or ? (a_in[i] | b_in[i]) : (a_in[i] & b_in[i]);
  end

endmodule

// File: rtl/alu5_core.sv
module alu5_core
  import alu5_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] res,
  output logic              zero_flag,
  output logic              ovf_flag,
  output logic              carry_flag
);

  alu_ctrl_t         ctrl;
  logic [DATA_W-1:0] sum_w;
  logic [DATA_W-1:0] logic_w;
  logic              cout_w;
  logic              ovf_w;
  logic              less_w;

  alu5_decode u_dec (
    .op_sel (op_sel),
    .ctrl   (ctrl)
  );

  alu5_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_in      (opnd_a),
    .b_in      (opnd_b),
    .negate_b  (ctrl.negate_b),
    .sum       (sum_w),
    .carry_out (cout_w),
    .ovf       (ovf_w),
    .less      (less_w)
  );

  alu5_logic #(.DATA_W(DATA_W)) u_logic (
    .a_in    (opnd_a),
    .b_in    (opnd_b),
    .pick_or (ctrl.pick_or),
    .y       (logic_w)
  );

  always_comb begin
    res        = '0;
    ovf_flag   = 1'b0;
    carry_flag = 1'b0;
    unique case (ctrl.src)
      SRC_LOGIC: res = logic_w;
      SRC_SUM: begin
        res        = sum_w;
        ovf_flag   = ovf_w;
        carry_flag = cout_w;
      end
      SRC_LESS: begin
        res        = {{(DATA_W-1){1'b0}}, less_w};
        ovf_flag   = ovf_w;
        carry_flag = cout_w;
      end
      default: res = '0;
    endcase
    zero_flag = ctrl.valid && (res == '0);
  end

  always_comb begin
    // R7: compare result only ever uses bit 0
    p_slt_shape_r7: assert (op_sel != OPC_SLT || res[DATA_W-1:1] == '0)
      else $error("compare result has upper bits set");
    // R9: logic codes never raise arithmetic flags
    p_logic_flags_r9: assert (!(op_sel == OPC_AND || op_sel == OPC_OR) ||
                              (!ovf_flag && !carry_flag))
      else $error("logic op raised a flag");
    // R10: unused codes give zero result and clear flags
    p_unused_quiet_r10: assert (!(op_sel == 3'b011 || op_sel == 3'b100 ||
                                  op_sel == 3'b101) ||
                                (res == '0 && !zero_flag && !ovf_flag && !carry_flag))
      else $error("unused code not quiet");
    // R3: add result matches the sum of the operands
    p_add_value_r3: assert (op_sel != OPC_ADD || res == opnd_a + opnd_b)
      else $error("add value mismatch");
  end

endmodule

// File: tb/tb_alu5_core.sv
module tb_alu5_core;

  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [2:0]   op_sel;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic [W-1:0] res;
  logic         zero_flag;
  logic         ovf_flag;
  logic         carry_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  alu5_core #(.DATA_W(W)) dut (
    .op_sel     (op_sel),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .res        (res),
    .zero_flag  (zero_flag),
    .ovf_flag   (ovf_flag),
    .carry_flag (carry_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b);
    longint unsigned ua, ub, full, mask;
    longint sa, sb, sres;
    longint unsigned e_res;
    bit e_ovf, e_cout, e_zero;
    string tr, tf;
    @(posedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    mask = (64'd1 << W) - 1;
    ua = a; ub = b;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    e_res = 0; e_ovf = 0; e_cout = 0; e_zero = 0;
    tr = "R10"; tf = "R10";
    case (op)
      3'b000: begin e_res = ua & ub; tr = "R1"; tf = "R9"; end
      3'b001: begin e_res = ua | ub; tr = "R2"; tf = "R9"; end
      3'b010: begin
        full = ua + ub; e_res = full & mask; e_cout = full[W];
        sres = sa + sb;
        e_ovf = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
        tr = "R3"; tf = "R5";
      end
      3'b110, 3'b111: begin
        full = ua + ((~ub) & mask) + 1; e_cout = full[W];
        sres = sa - sb;
        e_ovf = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
        if (op == 3'b110) begin e_res = full & mask; tr = "R4"; tf = "R6"; end
        else begin e_res = (sa < sb) ? 1 : 0; tr = "R7"; tf = "R7"; end
      end
      default: begin e_res = 0; end
    endcase
    if (op inside {3'b000, 3'b001, 3'b010, 3'b110, 3'b111}) e_zero = (e_res == 0);
    @(negedge clk);
    chk(tr, "result", longint'(res), longint'(e_res));
    chk(tf, "overflow", longint'(ovf_flag), longint'(e_ovf));
    chk(tr, "carry", longint'(carry_flag), longint'(e_cout));
    chk((op inside {3'b011, 3'b100, 3'b101}) ? "R10" : "R8", "zero",
        longint'(zero_flag), longint'(e_zero));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_sel = 3'b000; opnd_a = '0; opnd_b = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "zero after idle AND of zeros", longint'(zero_flag), 1);
    chk("R1", "idle result", longint'(res), 0);
    // R1/R2 logic patterns, R9 flags clear
    apply(3'b000, 32'hF0F0_A5A5, 32'hFF00_0FF0);
    apply(3'b001, 32'h0F0F_0000, 32'h0000_5A5A);
    apply(3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    apply(3'b000, 32'hAAAA_AAAA, 32'h5555_5555);
    // R3/R5 add: overflow at both ends, unsigned carry without overflow
    apply(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);
    apply(3'b010, 32'h8000_0000, 32'h8000_0000);
    apply(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);
    apply(3'b010, 32'h0000_1234, 32'h0000_4321);
    // R4/R6 subtract: equal operands, borrow, overflow both ways
    apply(3'b110, 32'h1234_5678, 32'h1234_5678);
    apply(3'b110, 32'h0000_0000, 32'h0000_0001);
    apply(3'b110, 32'h8000_0000, 32'h0000_0001);
    apply(3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    apply(3'b110, 32'h0000_0000, 32'h0000_0000);
    // R7 compare, including overflowing differences
    apply(3'b111, 32'h8000_0000, 32'h7FFF_FFFF);
    apply(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);
    apply(3'b111, 32'hFFFF_FFFF, 32'h0000_0001);
    apply(3'b111, 32'h0000_0005, 32'h0000_0005);
    apply(3'b111, 32'h0000_0003, 32'h0000_0009);
    // R10 unused codes with operands that would produce flags
    apply(3'b011, 32'h7FFF_FFFF, 32'h0000_0001);
    apply(3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    apply(3'b101, 32'h8000_0000, 32'h0000_0001);
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 7 == 0) rb = ra;
      if (i % 11 == 0) ra = {ra[W-1], {(W-1){~ra[W-1]}}};
      apply(3'(i % 8), ra, rb);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule